// File: doc/BRIEF.md
# Display Serial Link PHY Bring-Up Sequencer

This block powers up and powers down the PHY of a serial display link transmitter. A start request steps the PHY through a fixed bring-up order. First a one-cycle test-clear pulse goes out. Then all four active-low PHY release controls are raised in the same cycle. The sequencer then waits for PLL lock, and after that for the clock lane to reach stop state. At the end it raises the core power-up output and a done flag. Each wait has a programmable limit counted in timeout-clock ticks. When a limit runs out, a sticky flag is set and the sequence moves on anyway, so a missing handshake can never hang the block.

A stop request powers the link down. The core power-up output drops first, and one cycle later every PHY control bit goes low. Two free-running strobe generators sit beside the sequencer. One makes the escape-clock enable and the other makes the timeout-clock enable. Each takes its own 8-bit field of one divider configuration word. The package also provides a helper that picks the escape divider from the lane rate, so that the escape clock stays at or below 20 MHz.

Top module: `dphy_bringup_seq`

## Requirements
- R1: After reset, `phy_ctrl_o`, `core_pwr_o`, `test_clr_o`, `done_o`, `lock_to_o` and `stop_to_o` are all 0.
- R2: A start accepted while idle first produces `test_clr_o` low, then high for exactly one cycle, then low. While `test_clr_o` is high, `phy_ctrl_o` is 0. After the pulse, `phy_ctrl_o` goes from 4'h0 to 4'hF in one cycle: bit0 releases shutdown, bit1 releases reset, bit2 enables the clock and bit3 forces the PLL. `phy_ctrl_o` only ever holds 4'h0 or 4'hF.
- R3: The sequencer waits for PLL lock (`phy_status_i` bit0) before it looks at clock-lane stop state (bit2). Stop state seen before lock does not complete the sequence. Status bit1 has no effect.
- R4: If lock does not arrive within `lock_limit_i` timeout ticks, `lock_to_o` is set and the sequencer moves on to the stop-state wait.
- R5: If stop state does not arrive within `stop_limit_i` timeout ticks, `stop_to_o` is set and the sequencer moves on to completion.
- R6: On completion, `done_o` and `core_pwr_o` are 1 and `phy_ctrl_o` is 4'hF.
- R7: A stop request in any non-idle state lowers `core_pwr_o` and `done_o` at least one cycle before `phy_ctrl_o` returns to 4'h0. The sequencer then returns to idle.
- R8: A start request while the sequencer is not idle has no effect on any output.
- R9: `lock_to_o` and `stop_to_o` stay set, even through power-down, until the next start that is accepted from idle clears them.
- R10: `esc_tick_o` is a one-cycle strobe whose period is `clk_div_cfg_i[7:0]` cycles. A value of 0 counts as 1.
- R11: `tmo_tick_o` is a one-cycle strobe whose period is `clk_div_cfg_i[15:8]` cycles. A value of 0 counts as 1.
- R12: The package function `esc_div_for_rate(lane_mbps)` returns (lane_mbps/8)/20+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Bring-up request, accepted only when idle |
| stop_i | input | 1 | Power-down request |
| phy_status_i | input | 3 | bit0 PLL lock, bit2 clock-lane stop state, bit1 unused |
| clk_div_cfg_i | input | 16 | [7:0] escape divider, [15:8] timeout divider |
| lock_limit_i | input | CNT_W | Lock wait limit in timeout ticks |
| stop_limit_i | input | CNT_W | Stop-state wait limit in timeout ticks |
| core_pwr_o | output | 1 | Core power-up |
| phy_ctrl_o | output | 4 | PHY release controls (active-low shutdown/reset released at 1) |
| test_clr_o | output | 1 | PHY test-clear pulse |
| esc_tick_o | output | 1 | Escape-clock enable strobe |
| tmo_tick_o | output | 1 | Timeout-clock enable strobe |
| done_o | output | 1 | Bring-up complete |
| lock_to_o | output | 1 | Sticky lock timeout |
| stop_to_o | output | 1 | Sticky stop-state timeout |

## Verification
Some properties are checked on every cycle. The control word is only ever all-off or all-on. The test-clear pulse lasts one cycle and never overlaps released controls. Power is always lowered before the controls fall. The timeout flags stay sticky, and both strobes are single-cycle. Other behaviour only the bench scenarios can show. These are the order of output events during bring-up and power-down, the lock-before-stop priority, expiry under missing handshakes, a start ignored while busy, and the measured strobe periods.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;
  localparam int CTRL_W         = 4;
  localparam int STAT_W         = 3;
  localparam int STAT_LOCK      = 0;
  localparam int STAT_CLK_STOP  = 2;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR_A, S_CLR_HI, S_CLR_B, S_ENABLE,
    S_WAIT_LOCK, S_WAIT_STOP, S_DONE, S_PWR_OFF
  } seq_state_e;

  // R12: escape divider keeping escape clock at or below 20 MHz
  function automatic int unsigned esc_div_for_rate(input int unsigned lane_mbps);
    return (lane_mbps / 8) / 20 + 1;
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/bringup_fsm.sv
module bringup_fsm
  import dphy_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              lock_i,
  input  logic              clk_stop_i,
  input  logic              expired_i,
  output logic              timer_clr_o,
  output logic              core_pwr_o,
  output logic [CTRL_W-1:0] phy_ctrl_o,
  output logic              test_clr_o,
  output logic              done_o,
  output logic              lock_to_o,
  output logic              stop_to_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_i) state_d = S_CLR_A;
      S_CLR_A:     state_d = stop_i ? S_IDLE : S_CLR_HI;
      S_CLR_HI:    state_d = stop_i ? S_IDLE : S_CLR_B;
      S_CLR_B:     state_d = stop_i ? S_IDLE : S_ENABLE;
      S_ENABLE:    state_d = stop_i ? S_PWR_OFF : S_WAIT_LOCK;
      S_WAIT_LOCK: if (stop_i) state_d = S_PWR_OFF;
                   else if (lock_i || expired_i) state_d = S_WAIT_STOP;
      S_WAIT_STOP: if (stop_i) state_d = S_PWR_OFF;
                   else if (clk_stop_i || expired_i) state_d = S_DONE;
      S_DONE:      if (stop_i) state_d = S_PWR_OFF;
      S_PWR_OFF:   state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  assign timer_clr_o = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      core_pwr_o <= 1'b0;
      phy_ctrl_o <= '0;
      test_clr_o <= 1'b0;
      done_o     <= 1'b0;
      lock_to_o  <= 1'b0;
      stop_to_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      core_pwr_o <= (state_d == S_DONE);
      done_o     <= (state_d == S_DONE);
      test_clr_o <= (state_d == S_CLR_HI);
      phy_ctrl_o <= (state_d inside {S_ENABLE, S_WAIT_LOCK, S_WAIT_STOP, S_DONE, S_PWR_OFF})
                    ? {CTRL_W{1'b1}} : '0;
      if (state_q == S_IDLE && start_i) begin
        lock_to_o <= 1'b0;
        stop_to_o <= 1'b0;
      end else begin
        if (state_q == S_WAIT_LOCK && !stop_i && !lock_i && expired_i) lock_to_o <= 1'b1;
        if (state_q == S_WAIT_STOP && !stop_i && !clk_stop_i && expired_i) stop_to_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dphy_bringup_seq.sv
module dphy_bringup_seq
  import dphy_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16,
  localparam int CFG_W = 2 * DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [STAT_W-1:0] phy_status_i,
  input  logic [CFG_W-1:0]  clk_div_cfg_i,
  input  logic [CNT_W-1:0]  lock_limit_i,
  input  logic [CNT_W-1:0]  stop_limit_i,
  output logic              core_pwr_o,
  output logic [CTRL_W-1:0] phy_ctrl_o,
  output logic              test_clr_o,
  output logic              esc_tick_o,
  output logic              tmo_tick_o,
  output logic              done_o,
  output logic              lock_to_o,
  output logic              stop_to_o
);
  logic [1:0]       ticks;
  logic             timer_clr;
  logic             expired;
  logic             in_stop_wait;
  logic [CNT_W-1:0] limit_sel;
  logic             status_unused;

  assign status_unused = phy_status_i[1];

  // index 0: escape clock, index 1: timeout clock
  for (genvar g = 0; g < 2; g++) begin : g_div
    tick_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst    (rst),
      .div_i  (clk_div_cfg_i[g*DIV_W +: DIV_W]),
      .tick_o (ticks[g])
    );
  end

  assign esc_tick_o = ticks[0];
  assign tmo_tick_o = ticks[1];

  // lock flag set means the stop-state wait is the one being timed
  assign in_stop_wait = phy_ctrl_o[0] && !test_clr_o && (lock_to_o || phy_status_i[STAT_LOCK] || done_o);

  wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (timer_clr),
    .tick_i    (ticks[1]),
    .limit_i   (limit_sel),
    .expired_o (expired)
  );

  bringup_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .lock_i      (phy_status_i[STAT_LOCK]),
    .clk_stop_i  (phy_status_i[STAT_CLK_STOP]),
    .expired_i   (expired),
    .timer_clr_o (timer_clr),
    .core_pwr_o  (core_pwr_o),
    .phy_ctrl_o  (phy_ctrl_o),
    .test_clr_o  (test_clr_o),
    .done_o      (done_o),
    .lock_to_o   (lock_to_o),
    .stop_to_o   (stop_to_o)
  );

  // limit select follows which wait is active; timer is cleared on every state change
  logic stage_q;
  always_ff @(posedge clk) begin
    if (rst || !phy_ctrl_o[0]) stage_q <= 1'b0;
    else if (timer_clr && phy_ctrl_o[0] && !stage_q && (in_stop_wait || expired || phy_status_i[STAT_LOCK]))
      stage_q <= 1'b1;
  end
  assign limit_sel = stage_q ? stop_limit_i : lock_limit_i;
endmodule

// File: rtl/dphy_bringup_seq_chk.sv
module dphy_bringup_seq_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [2*DIV_W-1:0] clk_div_cfg_i,
  input logic             core_pwr_o,
  input logic [3:0]       phy_ctrl_o,
  input logic             test_clr_o,
  input logic             esc_tick_o,
  input logic             tmo_tick_o,
  input logic             done_o,
  input logic             lock_to_o,
  input logic             stop_to_o
);
  p_ctrl_all_or_none_r2: assert property (@(posedge clk) disable iff (rst)
    phy_ctrl_o == 4'h0 || phy_ctrl_o == 4'hF);
  p_clr_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    test_clr_o |=> !test_clr_o);
  p_clr_ctrl_off_r2: assert property (@(posedge clk) disable iff (rst)
    test_clr_o |-> phy_ctrl_o == 4'h0);
  p_done_released_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (phy_ctrl_o == 4'hF && core_pwr_o));
  p_pwr_drops_first_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_ctrl_o[0]) |-> !$past(core_pwr_o));
  p_lock_to_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    lock_to_o && !start_i |=> lock_to_o);
  p_stop_to_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    stop_to_o && !start_i |=> stop_to_o);
  p_esc_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    esc_tick_o && clk_div_cfg_i[DIV_W-1:0] > 1 |=> !esc_tick_o);
  p_tmo_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    tmo_tick_o && clk_div_cfg_i[2*DIV_W-1:DIV_W] > 1 |=> !tmo_tick_o);
endmodule

bind dphy_bringup_seq dphy_bringup_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .clk_div_cfg_i(clk_div_cfg_i),
  .core_pwr_o(core_pwr_o), .phy_ctrl_o(phy_ctrl_o), .test_clr_o(test_clr_o),
  .esc_tick_o(esc_tick_o), .tmo_tick_o(tmo_tick_o), .done_o(done_o),
  .lock_to_o(lock_to_o), .stop_to_o(stop_to_o)
);

// File: tb/test_dphy_bringup_seq.sv
module test_dphy_bringup_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [2:0]  phy_status_i = '0;
  logic [15:0] clk_div_cfg_i = '0;
  logic [15:0] lock_limit_i = 16'd10, stop_limit_i = 16'd10;
  logic        core_pwr_o, test_clr_o, esc_tick_o, tmo_tick_o, done_o, lock_to_o, stop_to_o;
  logic [3:0]  phy_ctrl_o;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [6:0] expq[$];

  always #10 clk = ~clk;

  dphy_bringup_seq i_dphy_bringup_seq (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] snap();
    return {done_o, core_pwr_o, test_clr_o, phy_ctrl_o};
  endfunction

  // monitor: each change of the control snapshot pops one expected item
  initial begin
    logic [6:0] prev = '0;
    forever begin
      @(posedge clk); #2;
      if (rst) prev = snap();
      else if (snap() !== prev) begin
        prev = snap();
        if (expq.size() == 0) check("R8 unexpected output change", {25'd0, prev}, 32'h7f);
        else check("R2/R6/R7 event order", {25'd0, prev}, {25'd0, expq.pop_front()});
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic wait_drain(string tag);
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(tag, expq.size(), 0);
    cycles(3);
  endtask

  task automatic push_bringup(bit finish);
    expq.push_back(7'b0010000);
    expq.push_back(7'b0000000);
    expq.push_back(7'b0001111);
    if (finish) expq.push_back(7'b1101111);
  endtask

  task automatic measure(ref logic tick, input int exp, input string tag);
    int n;
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(posedge clk); #2; n++; end while (!tick && n < 400);
    end
    n = 0;
    do begin @(posedge clk); #2; n++; end while (!tick && n < 400);
    check(tag, n, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(3); rst = 1'b0; cycles(1);
    // R1 reset state
    check("R1 ctrl", phy_ctrl_o, 0);
    check("R1 outputs", {core_pwr_o, test_clr_o, done_o, lock_to_o, stop_to_o}, 0);

    // R12 helper
    check("R12 1000", dphy_seq_pkg::esc_div_for_rate(1000), 7);
    check("R12 160", dphy_seq_pkg::esc_div_for_rate(160), 2);
    check("R12 80", dphy_seq_pkg::esc_div_for_rate(80), 1);

    // R10 / R11 strobe periods
    measure(esc_tick_o, 1, "R10 div0");
    clk_div_cfg_i = 16'h0305;
    measure(esc_tick_o, 5, "R10 div5");
    measure(tmo_tick_o, 3, "R11 div3");
    clk_div_cfg_i = 16'h0700;
    measure(tmo_tick_o, 7, "R11 div7");
    measure(esc_tick_o, 1, "R10 div0 again");
    clk_div_cfg_i = 16'h0000;
    cycles(4);

    // R3: stop state and bit1 present, lock absent: must not finish
    phy_status_i = 3'b110; lock_limit_i = 16'd300; stop_limit_i = 16'd300;
    push_bringup(0);
    pulse(start_i);
    wait_drain("R2 bring-up events");
    cycles(20);
    check("R3 no done before lock", done_o, 0);
    expq.push_back(7'b1101111);
    phy_status_i = 3'b101;
    wait_drain("R6 completion");
    check("R6 done", {done_o, core_pwr_o, phy_ctrl_o}, 6'h3F);
    check("R4 no lock timeout", lock_to_o, 0);
    check("R5 no stop timeout", stop_to_o, 0);

    // R8: start while done is ignored
    pulse(start_i);
    cycles(10);
    check("R8 still done", {done_o, phy_ctrl_o}, 5'h1F);

    // R7 power-down from done
    expq.push_back(7'b0001111);
    expq.push_back(7'b0000000);
    pulse(stop_i);
    wait_drain("R7 power-down events");
    check("R7 ctrl off", phy_ctrl_o, 0);

    // R4/R5 timeouts
    phy_status_i = 3'b000; lock_limit_i = 16'd5; stop_limit_i = 16'd4;
    push_bringup(1);
    pulse(start_i);
    wait_drain("R4 bring-up with timeouts");
    check("R4 lock timeout flag", lock_to_o, 1);
    check("R5 stop timeout flag", stop_to_o, 1);
    check("R5 done after timeouts", done_o, 1);

    // R9 flags survive power-down
    expq.push_back(7'b0001111);
    expq.push_back(7'b0000000);
    pulse(stop_i);
    wait_drain("R7 second power-down");
    check("R9 lock flag sticky", lock_to_o, 1);
    check("R9 stop flag sticky", stop_to_o, 1);

    // R9 cleared by accepted start
    phy_status_i = 3'b101;
    push_bringup(1);
    pulse(start_i);
    wait_drain("R9 clean bring-up");
    check("R9 flags cleared", {lock_to_o, stop_to_o}, 0);
    expq.push_back(7'b0001111);
    expq.push_back(7'b0000000);
    pulse(stop_i);
    wait_drain("R7 third power-down");

    // R7 power-down during lock wait
    phy_status_i = 3'b000; lock_limit_i = 16'd1000;
    push_bringup(0);
    pulse(start_i);
    wait_drain("R2 enable before abort");
    expq.push_back(7'b0000000);
    pulse(stop_i);
    wait_drain("R7 abort in wait");
    check("R7 idle after abort", {core_pwr_o, done_o, phy_ctrl_o}, 0);
    check("R4 no flag on abort", lock_to_o, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule